// File: doc/BRIEF.md
# Output-Compare PWM Channel

This block is a single compare channel that sits beside a timer time-base. Each clock it receives the running count, the counting direction and an update-event pulse from that time-base, compares the count with its own compare value, and from the result builds an internal reference level. The reference is then inverted or not, and gated by an enable, to give one output pin.

A 3-bit mode chooses how the reference reacts. It can stay as it is, be set or cleared when the count equals the compare value, toggle on each such equality, be held low or high, or follow one of two PWM shapes built from the comparison "count below compare". The compare value is written through a strobe. With preloading on, the written value waits in a buffer until the next update pulse. With preloading off, it takes effect at once. The same comparison serves edge-aligned time-bases, which count up or down, and center-aligned ones, which count up and then down. In the center-aligned case it gives a pulse centred on count 0.

Top module: `ocpwm_channel`

## Requirements
- R1: After reset, the pin is low, the reference is inactive, the mode is 000, preloading, inversion and enable are off, and the compare value is 0.
- R2: The configuration fields `cfg_mode_i`, `cfg_preload_i`, `cfg_invert_i` and `cfg_enable_i` are captured on a clock edge where `cfg_we_i` is high. They govern the edges that follow. The reference is a register: after edge k it reflects the count that was presented at edge k.
- R3: Mode 000 (frozen): the reference keeps its value whatever the count.
- R4: Mode 001 makes the reference active when the count equals the compare value. Mode 010 makes it inactive on that equality. Otherwise both modes hold it.
- R5: Mode 011 inverts the reference once for each arrival of the count at the compare value. An arrival means the count or the direction differs from the previous edge, or it is the first edge after reset. A count that stays equal toggles only once.
- R6: Mode 100 holds the reference inactive and mode 101 holds it active, regardless of the count.
- R7: Mode 110 makes the reference active exactly when count < compare. For an up-count from 0 to ARR this gives a duty of compare/(ARR+1). Examples: ARR=8 and compare 5 give 5 of every 9 ticks, ARR=999 and compare 250 give 250 of every 1000 ticks. A compare above ARR gives 100%, and a compare of 0 gives 0%.
- R8: Mode 111 makes the reference inactive exactly when count < compare, and active otherwise.
- R9: In center-aligned counting (0 up to ARR, then down to 1), mode 110 is active on both slopes while count < compare. This gives one contiguous pulse of 2*compare-1 ticks around count 0 when 0 < compare <= ARR.
- R10: With preloading off, a compare write is used from the next edge. With preloading on, writes go to a buffer and the active value changes only on an edge with `upd_i` high. A write and an update on the same edge load the new data.
- R11: With the enable on, the pin equals the reference when inversion is 0 and its complement when inversion is 1.
- R12: With the enable off, the pin is low whatever the reference and the inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current time-base count |
| cnt_down_i | input | 1 | Time-base direction, 1 = counting down |
| upd_i | input | 1 | Update-event pulse from the time-base |
| ccr_we_i | input | 1 | Compare value write strobe |
| ccr_wdata_i | input | CNT_W | Compare value write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Compare mode code |
| cfg_preload_i | input | 1 | Compare preload enable |
| cfg_invert_i | input | 1 | Output polarity, 1 = active low |
| cfg_enable_i | input | 1 | Output enable |
| pin_o | output | 1 | Channel output level |

## Verification
The assertions assume the count and the direction are those of a legal time-base. They also assume strobes are single-cycle writes with stable data, and that `upd_i` appears only at period boundaries, although no property fails if it comes elsewhere. The bench holds to this. It drives its count sequences as whole up-count or up-down periods, changes each input only away from the clock edge, and issues configuration and compare writes while the count stands still. A standing count is not an arrival, so these writes never add a compare event of their own.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TGL    = 3'b011,
    OCM_LO     = 3'b100,
    OCM_HI     = 3'b101,
    OCM_PWMA   = 3'b110,
    OCM_PWMB   = 3'b111
  } ocm_e;

  typedef struct packed {
    ocm_e mode;
    logic preload;
    logic invert;
    logic enable;
  } ocpwm_cfg_t;

  // Next reference level from mode, current level, arrival event and below flag.
  function automatic logic next_ref(input ocm_e mode, input logic cur,
                                    input logic evt, input logic lt);
    logic r;
    case (mode)
      OCM_FROZEN: r = cur;
      OCM_SET:    r = evt ? 1'b1 : cur;
      OCM_CLR:    r = evt ? 1'b0 : cur;
      OCM_TGL:    r = evt ? ~cur : cur;
      OCM_LO:     r = 1'b0;
      OCM_HI:     r = 1'b1;
      OCM_PWMA:   r = lt;
      default:    r = ~lt;
    endcase
    return r;
  endfunction

  // Pin level from reference, polarity and enable.
  function automatic logic pin_level(input logic rf, input logic inv, input logic en);
    return en & (rf ^ inv);
  endfunction

endpackage

// File: rtl/ocpwm_ccr_buf.sv
module ocpwm_ccr_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] ccr_act_o
);
  logic [CNT_W-1:0] pre_q, act_q;
  logic [CNT_W-1:0] pre_next;

  assign pre_next = we_i ? wdata_i : pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_next;
      if (!preload_i) begin
        if (we_i) act_q <= wdata_i;
      end else if (upd_i) begin
        act_q <= pre_next;
      end
    end
  end

  assign ccr_act_o = act_q;
endmodule

// File: rtl/ocpwm_refgen.sv
module ocpwm_refgen
  import ocpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  ocm_e             mode_i,
  output logic             match_evt_o,
  output logic             below_o,
  output logic             ref_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q, seen_q, ref_q;
  logic             arrival, equal;

  assign equal       = (cnt_i == ccr_i);
  assign arrival     = !seen_q || (cnt_i != cnt_q) || (cnt_down_i != dir_q);
  assign match_evt_o = equal && arrival;
  assign below_o     = (cnt_i < ccr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      seen_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_i;
      dir_q  <= cnt_down_i;
      seen_q <= 1'b1;
      ref_q  <= next_ref(mode_i, ref_q, match_evt_o, below_o);
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/ocpwm_outstage.sv
module ocpwm_outstage
  import ocpwm_pkg::*;
(
  input  logic ref_i,
  input  logic invert_i,
  input  logic enable_i,
  output logic pin_o
);
  assign pin_o = pin_level(ref_i, invert_i, enable_i);
endmodule

// File: rtl/ocpwm_channel.sv
module ocpwm_channel
  import ocpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_wdata_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_preload_i,
  input  logic             cfg_invert_i,
  input  logic             cfg_enable_i,
  output logic             pin_o
);
  ocpwm_cfg_t       cfg_q;
  logic [CNT_W-1:0] ccr_act;
  logic             match_evt, below, oc_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: OCM_FROZEN, preload: 1'b0, invert: 1'b0, enable: 1'b0};
    end else if (cfg_we_i) begin
      cfg_q <= '{mode: ocm_e'(cfg_mode_i), preload: cfg_preload_i,
                 invert: cfg_invert_i, enable: cfg_enable_i};
    end
  end

  ocpwm_ccr_buf #(.CNT_W(CNT_W)) u_ccr (
    .clk_i(clk_i), .rst_ni(rst_ni), .preload_i(cfg_q.preload),
    .we_i(ccr_we_i), .wdata_i(ccr_wdata_i), .upd_i(upd_i), .ccr_act_o(ccr_act)
  );

  ocpwm_refgen #(.CNT_W(CNT_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
    .ccr_i(ccr_act), .mode_i(cfg_q.mode), .match_evt_o(match_evt),
    .below_o(below), .ref_o(oc_ref)
  );

  ocpwm_outstage u_out (
    .ref_i(oc_ref), .invert_i(cfg_q.invert), .enable_i(cfg_q.enable), .pin_o(pin_o)
  );
endmodule

// File: rtl/ocpwm_chk.sv
module ocpwm_chk
  import ocpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_i,
  input logic             ccr_we_i,
  input logic [2:0]       mode,
  input logic             preload,
  input logic             invert,
  input logic             enable,
  input logic [CNT_W-1:0] ccr_act,
  input logic             match_evt,
  input logic             oc_ref,
  input logic             pin_o
);
  assert_frozen_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'b000) |=> $stable(oc_ref));

  assert_set_on_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'b001 && match_evt) |=> oc_ref);

  assert_toggle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'b011 && !match_evt) |=> $stable(oc_ref));

  assert_force_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'b101) |=> oc_ref);

  assert_force_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'b100) |=> !oc_ref);

  assert_preload_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload && !upd_i) |=> $stable(ccr_act));

  assert_direct_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload && !ccr_we_i) |=> $stable(ccr_act));

  assert_polarity_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable |-> (pin_o == (oc_ref ^ invert)));

  assert_disabled_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> !pin_o);
endmodule

bind ocpwm_channel ocpwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .ccr_we_i(ccr_we_i),
  .mode(cfg_q.mode), .preload(cfg_q.preload), .invert(cfg_q.invert),
  .enable(cfg_q.enable), .ccr_act(ccr_act), .match_evt(match_evt),
  .oc_ref(oc_ref), .pin_o(pin_o)
);

// File: tb/sim_ocpwm_channel.sv
module sim_ocpwm_channel;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt = '0, wdata = '0;
  logic dir = 1'b0, upd = 1'b0, ccr_we = 1'b0, cfg_we = 1'b0;
  logic [2:0] mode_in = '0;
  logic pre_in = 1'b0, inv_in = 1'b0, en_in = 1'b0;
  logic pin;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state derived from the requirements
  logic [2:0] m_mode = '0;
  logic m_pre = 0, m_inv = 0, m_en = 0, m_ref = 0, m_seen = 0, m_dir = 0;
  logic [W-1:0] m_act = '0, m_buf = '0, m_cnt = '0;

  always #2.5 clk = ~clk;

  ocpwm_channel #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(dir), .upd_i(upd),
    .ccr_we_i(ccr_we), .ccr_wdata_i(wdata), .cfg_we_i(cfg_we),
    .cfg_mode_i(mode_in), .cfg_preload_i(pre_in), .cfg_invert_i(inv_in),
    .cfg_enable_i(en_in), .pin_o(pin)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pin=%0b expected=%0b (cnt=%0d mode=%0d t=%0t)",
               req, act, exp, cnt, m_mode, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: model the edge, then sample away from it.
  task automatic cyc(input string req);
    logic arr, eq;
    @(posedge clk);
    arr = !m_seen || (cnt != m_cnt) || (dir != m_dir);
    eq  = (cnt == m_act);
    case (m_mode)
      3'd1: if (eq && arr) m_ref = 1;
      3'd2: if (eq && arr) m_ref = 0;
      3'd3: if (eq && arr) m_ref = !m_ref;
      3'd4: m_ref = 0;
      3'd5: m_ref = 1;
      3'd6: m_ref = (cnt < m_act);
      3'd7: m_ref = !(cnt < m_act);
      default: ;
    endcase
    m_seen = 1; m_cnt = cnt; m_dir = dir;
    if (ccr_we) begin
      if (!m_pre) m_act = wdata;
      m_buf = wdata;
    end
    if (upd && m_pre) m_act = m_buf;
    if (cfg_we) begin
      m_mode = mode_in; m_pre = pre_in; m_inv = inv_in; m_en = en_in;
    end
    #1;
    check(req, pin, m_en & (m_ref ^ m_inv));
    ccr_we = 0; cfg_we = 0; upd = 0;
  endtask

  task automatic set_cfg(input logic [2:0] md, input logic p, input logic iv, input logic e);
    mode_in = md; pre_in = p; inv_in = iv; en_in = e; cfg_we = 1;
    cyc("R2");
  endtask

  task automatic wr_ccr(input int v);
    wdata = W'(v); ccr_we = 1;
    cyc("R10");
  endtask

  task automatic step(input int c, input logic d, input string req);
    cnt = W'(c); dir = d;
    cyc(req);
  endtask

  // Up-count period 0..arr, returns number of high pin samples.
  task automatic up_period(input int arr, input string req, output int hi);
    hi = 0;
    for (int c = 0; c <= arr; c++) begin
      step(c, 0, req);
      hi += int'(pin);
    end
  endtask

  initial begin
    int hi;
    #1;
    #12 rst_n = 1;
    #0.5;
    check("R1", pin, 1'b0);
    @(negedge clk);

    // PWM1 duty sweep, ARR=8
    set_cfg(3'd6, 0, 0, 1);
    for (int v = 0; v <= 10; v++) begin
      wr_ccr(v);
      up_period(8, "R7", hi);
      check_int("R7", hi, (v > 9) ? 9 : v);
    end
    wr_ccr(5); up_period(8, "R7", hi); check_int("R7 5of9", hi, 5);
    wr_ccr(250); up_period(999, "R7", hi); check_int("R7 25pct", hi, 250);

    // PWM2
    set_cfg(3'd7, 0, 0, 1);
    for (int v = 0; v <= 10; v += 2) begin
      wr_ccr(v);
      up_period(8, "R8", hi);
      check_int("R8", hi, 9 - ((v > 9) ? 9 : v));
    end

    // Center-aligned PWM1
    set_cfg(3'd6, 0, 0, 1);
    for (int v = 1; v <= 8; v++) begin
      wr_ccr(v);
      hi = 0;
      for (int c = 0; c <= 8; c++) begin step(c, 0, "R9"); hi += int'(pin); end
      for (int c = 7; c >= 1; c--) begin step(c, 1, "R9"); hi += int'(pin); end
      check_int("R9", hi, 2 * v - 1);
    end

    // Set / clear / toggle / frozen
    wr_ccr(3);
    set_cfg(3'd2, 0, 0, 1);
    for (int k = 0; k < 2; k++) for (int c = 0; c <= 8; c++) step(c, 0, "R4");
    check("R4 clr", pin, 1'b0);
    set_cfg(3'd1, 0, 0, 1);
    for (int c = 0; c <= 8; c++) step(c, 0, "R4");
    check("R4 set", pin, 1'b1);
    set_cfg(3'd3, 0, 0, 1);
    for (int k = 0; k < 3; k++) for (int c = 0; c <= 8; c++) step(c, 0, "R5");
    check("R5 odd", pin, 1'b0);
    for (int k = 0; k < 4; k++) step(3, 0, "R5");
    check("R5 held", pin, 1'b1);
    step(3, 1, "R5");
    check("R5 dir", pin, 1'b0);
    set_cfg(3'd0, 0, 0, 1);
    for (int c = 0; c <= 8; c++) step(c, 0, "R3");
    check("R3", pin, 1'b0);

    // Forced levels with polarity and enable
    for (int md = 4; md <= 5; md++)
      for (int iv = 0; iv <= 1; iv++)
        for (int e = 0; e <= 1; e++) begin
          set_cfg(3'(md), 0, 1'(iv), 1'(e));
          for (int c = 0; c <= 8; c++) step(c, 0, "R6");
          check(e ? "R11" : "R12", pin, 1'(e) & (1'(md - 4) ^ 1'(iv)));
        end

    // Preload: buffered until update
    set_cfg(3'd6, 1, 0, 1);
    wr_ccr(2);
    cnt = 0; upd = 1; cyc("R10");
    wr_ccr(7);
    up_period(8, "R10", hi); check_int("R10 held", hi, 2);
    cnt = 0; upd = 1; cyc("R10");
    up_period(8, "R10", hi); check_int("R10 loaded", hi, 7);
    wdata = 4; ccr_we = 1; upd = 1; cnt = 0; cyc("R10");
    up_period(8, "R10", hi); check_int("R10 same", hi, 4);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule